// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block turns single bus-cycle requests from a flash sequencer into correctly spaced write-enable and read-enable strobe waveforms on a NAND flash bus. A request names one of five cycle kinds: command latch, address latch, data-in write, data-out read, or a wait on the device's ready/busy line. For each request the block runs a setup gap, a strobe-low phase and a strobe-high phase, then pulses a completion flag. A read cycle also returns the byte it captured.

All phase lengths come from two timing words that software programs in clock cycles. Some fields are stored with a fixed offset: the setup field is one cycle short, and the read-setup group and address-to-data fields are two cycles short. The hardware adds the offset back. The setup field stands for the largest of the chip-enable and latch setup and hold times. The read-setup field stands for the largest of the three read-turnaround times. A field of zero still gives every strobe phase at least one clock.

The timing words are sampled when a request is accepted. Software may rewrite them at any time: a change made during a cycle takes effect on the following cycle.

Top module: `nand_strobe_timer`

## Requirements
- R1: After reset, we_n and re_n are 1, cle, ale, dq_oe and done are 0, req_ready is 1 and rd_byte is 0.
- R2: A write cycle (req_kind 0 = command, 1 = address, 2 = data-in) has three phases. The setup phase lasts tim_a[15:12]+1 clocks. we_n is then low for max(tim_a[23:20],1) clocks and high for max(tim_a[19:16],1) clocks. cle is high through the cycle for kind 0 and ale for kind 1. dq_oe is high and dq_out carries req_byte through all write cycles.
- R3: A data-in write that directly follows an address write uses a setup phase of max(tim_a[15:12]+1, tim_b[3:0]+2) clocks.
- R4: A read cycle (req_kind 3) has a setup phase of tim_a[31:28]+2 clocks, or max(tim_a[31:28]+2, max(tim_a[11:8],1)) clocks when the previous request was a write. re_n is then low for max(tim_a[3:0],1) clocks and high for max(tim_a[27:24],1) clocks.
- R5: A read captures dq_in on the clock edge that ends the re_n low phase and holds it on rd_byte until the next read captures. done pulses for one clock, with req_ready high, right after the high phase of every cycle.
- R6: A wait request (req_kind 4) waits max(tim_a[7:4],1) clocks and then samples rb_n on each clock. It completes on the first clock edge that sees rb_n = 1. req_ready stays low throughout.
- R7: The timing words are sampled when a request is accepted. A change made while a cycle runs affects only later cycles.
- R8: A request with req_kind 5, 6 or 7 is ignored: the block stays ready, drives no strobe and gives no done.
- R9: A request is accepted only while req_ready is 1, and req_ready falls on the next clock. we_n and re_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tim_a | input | 32 | Main timing word, eight 4-bit count fields |
| tim_b | input | 4 | Address-to-data gap field (cycles minus 2) |
| req_valid | input | 1 | Cycle request strobe |
| req_kind | input | 3 | Cycle kind code |
| req_byte | input | 8 | Byte to drive for write cycles |
| req_ready | output | 1 | Block idle, a request is accepted |
| done | output | 1 | One-clock cycle-complete pulse |
| rd_byte | output | 8 | Byte captured by the last read |
| we_n | output | 1 | Write-enable strobe, active low |
| re_n | output | 1 | Read-enable strobe, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| dq_out | output | 8 | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |
| dq_in | input | 8 | Data bus input value |
| rb_n | input | 1 | Device ready (1) or busy (0) |

## Verification
The main phase timing is exercised in four ways. A command, address, data-in, data-in, read, read sequence shows that the address-to-data and write-to-read gaps are applied only after the right predecessor. An all-zero timing set shows the one-clock floor and the offset fields. Rewriting a field in the middle of a cycle tells sampling at acceptance apart from live use. Wait requests run once with the device already ready and once with it held busy past the minimum wait, which separates the fixed wait from the polling. Undefined kind codes are issued between valid requests to show they leave the bus idle.

// File: rtl/nst_pkg.sv
package nst_pkg;
  localparam int NFLD = 8;
  localparam logic [2:0] K_CMD   = 3'd0;
  localparam logic [2:0] K_ADDR  = 3'd1;
  localparam logic [2:0] K_WDATA = 3'd2;
  localparam logic [2:0] K_RDATA = 3'd3;
  localparam logic [2:0] K_WAIT  = 3'd4;

  // field slots inside the main timing word
  localparam int F_RLOW  = 0;
  localparam int F_BWAIT = 1;
  localparam int F_W2R   = 2;
  localparam int F_SETUP = 3;
  localparam int F_WHIGH = 4;
  localparam int F_WLOW  = 5;
  localparam int F_RHIGH = 6;
  localparam int F_RSET  = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH, ST_BWAIT, ST_POLL
  } state_e;
endpackage

// File: rtl/nst_phase_calc.sv
module nst_phase_calc
  import nst_pkg::*;
#(
  parameter int FW = 4,
  parameter int CW = FW + 2
) (
  input  logic [NFLD*FW-1:0] tim_a,
  input  logic [FW-1:0]      tim_b,
  input  logic [2:0]         kind,
  input  logic               prev_addr,
  input  logic               prev_write,
  output logic [CW-1:0]      setup_len,
  output logic [CW-1:0]      low_len,
  output logic [CW-1:0]      high_len
);
  logic [CW-1:0] fld [NFLD];
  logic [CW-1:0] adl;
  logic          is_wr;

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    assign fld[i] = CW'(tim_a[i*FW +: FW]);
  end
  assign adl   = CW'(tim_b);
  assign is_wr = (kind == K_CMD) || (kind == K_ADDR) || (kind == K_WDATA);

  function automatic logic [CW-1:0] floor1(input logic [CW-1:0] x);
    return (x == '0) ? CW'(1) : x;
  endfunction

  function automatic logic [CW-1:0] max2(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  always_comb begin
    low_len  = is_wr ? floor1(fld[F_WLOW])  : floor1(fld[F_RLOW]);
    high_len = is_wr ? floor1(fld[F_WHIGH]) : floor1(fld[F_RHIGH]);
    case (kind)
      K_RDATA: setup_len = prev_write ? max2(fld[F_RSET] + CW'(2), floor1(fld[F_W2R]))
                                      : fld[F_RSET] + CW'(2);
      K_WAIT:  setup_len = floor1(fld[F_BWAIT]);
      K_WDATA: setup_len = prev_addr ? max2(fld[F_SETUP] + CW'(1), adl + CW'(2))
                                     : fld[F_SETUP] + CW'(1);
      default: setup_len = fld[F_SETUP] + CW'(1);
    endcase
  end
endmodule

// File: rtl/nst_down_counter.sv
module nst_down_counter #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer
  import nst_pkg::*;
#(
  parameter int FW = 4,
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NFLD*FW-1:0] tim_a,
  input  logic [FW-1:0]      tim_b,
  input  logic               req_valid,
  input  logic [2:0]         req_kind,
  input  logic [DW-1:0]      req_byte,
  output logic               req_ready,
  output logic               done,
  output logic [DW-1:0]      rd_byte,
  output logic               we_n,
  output logic               re_n,
  output logic               cle,
  output logic               ale,
  output logic [DW-1:0]      dq_out,
  output logic               dq_oe,
  input  logic [DW-1:0]      dq_in,
  input  logic               rb_n
);
  localparam int CW = FW + 2;
  localparam int TW = NFLD * FW;

  state_e        state_q, state_d;
  logic [TW-1:0] tima_q;
  logic [FW-1:0] timb_q;
  logic [2:0]    kind_q;
  logic [DW-1:0] byte_q, rd_q;
  logic          prev_addr_q, prev_write_q, done_q, done_d;
  logic          accept, kind_ok, idle, cnt_load, cnt_last, capture, is_wr_q, active;
  logic [CW-1:0] cnt_val, setup_len, low_len, high_len;
  logic [TW-1:0] calc_tima;
  logic [FW-1:0] calc_timb;
  logic [2:0]    calc_kind;

  assign idle    = (state_q == ST_IDLE);
  assign kind_ok = (req_kind <= K_WAIT);
  assign accept  = idle && req_valid && kind_ok;

  // live timing words while idle, sampled copy once a cycle runs
  assign calc_tima = idle ? tim_a    : tima_q;
  assign calc_timb = idle ? tim_b    : timb_q;
  assign calc_kind = idle ? req_kind : kind_q;

  nst_phase_calc #(.FW(FW), .CW(CW)) u_calc (
    .tim_a      (calc_tima),
    .tim_b      (calc_timb),
    .kind       (calc_kind),
    .prev_addr  (prev_addr_q),
    .prev_write (prev_write_q),
    .setup_len  (setup_len),
    .low_len    (low_len),
    .high_len   (high_len)
  );

  nst_down_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .last     (cnt_last)
  );

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    done_d   = 1'b0;
    capture  = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) begin
        cnt_load = 1'b1;
        cnt_val  = setup_len - CW'(1);
        state_d  = (req_kind == K_WAIT) ? ST_BWAIT : ST_SETUP;
      end
      ST_SETUP: if (cnt_last) begin
        state_d  = ST_LOW;
        cnt_load = 1'b1;
        cnt_val  = low_len - CW'(1);
      end
      ST_LOW: if (cnt_last) begin
        state_d  = ST_HIGH;
        cnt_load = 1'b1;
        cnt_val  = high_len - CW'(1);
        capture  = (kind_q == K_RDATA);
      end
      ST_HIGH: if (cnt_last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      ST_BWAIT: if (cnt_last) state_d = ST_POLL;
      ST_POLL: if (rb_n) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tima_q       <= '0;
      timb_q       <= '0;
      kind_q       <= K_CMD;
      byte_q       <= '0;
      prev_addr_q  <= 1'b0;
      prev_write_q <= 1'b0;
    end else if (accept) begin
      tima_q       <= tim_a;
      timb_q       <= tim_b;
      kind_q       <= req_kind;
      byte_q       <= req_byte;
      prev_addr_q  <= (req_kind == K_ADDR);
      prev_write_q <= (req_kind == K_CMD) || (req_kind == K_ADDR) || (req_kind == K_WDATA);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (capture) rd_q <= dq_in;
  end

  assign is_wr_q   = (kind_q == K_CMD) || (kind_q == K_ADDR) || (kind_q == K_WDATA);
  assign active    = (state_q == ST_SETUP) || (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign we_n      = !((state_q == ST_LOW) && is_wr_q);
  assign re_n      = !((state_q == ST_LOW) && (kind_q == K_RDATA));
  assign cle       = active && (kind_q == K_CMD);
  assign ale       = active && (kind_q == K_ADDR);
  assign dq_oe     = active && is_wr_q;
  assign dq_out    = byte_q;
  assign req_ready = idle;
  assign done      = done_q;
  assign rd_byte   = rd_q;
endmodule

// File: rtl/nst_checker.sv
module nst_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [2:0]    req_kind,
  input logic          req_ready,
  input logic          done,
  input logic [DW-1:0] rd_byte,
  input logic          we_n,
  input logic          re_n,
  input logic          cle,
  input logic          ale,
  input logic          dq_oe
);
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && req_kind <= 3'd4) |=> !req_ready);

  a_r8_bad_kind_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && (!req_valid || req_kind > 3'd4)) |=> (req_ready && !done && we_n && re_n));

  a_r5_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (re_n && $past(re_n)) |-> $stable(rd_byte));

  a_r2_oe_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

  a_r2_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
endmodule

bind nand_strobe_timer nst_checker #(.DW(DW)) u_nst_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .req_ready (req_ready),
  .done      (done),
  .rd_byte   (rd_byte),
  .we_n      (we_n),
  .re_n      (re_n),
  .cle       (cle),
  .ale       (ale),
  .dq_oe     (dq_oe)
);

// File: tb/nand_strobe_timer_tb.sv
module nand_strobe_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tim_a = '0;
  logic [3:0]  tim_b = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [7:0]  req_byte = '0;
  logic        req_ready, done, we_n, re_n, cle, ale, dq_oe;
  logic [7:0]  rd_byte, dq_out;
  logic [7:0]  dq_in = '0;
  logic        rb_n = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  int n_done = 0;
  int n_exp = 0;

  always #2 clk = ~clk;

  nand_strobe_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tim_a(tim_a), .tim_b(tim_b),
    .req_valid(req_valid), .req_kind(req_kind), .req_byte(req_byte),
    .req_ready(req_ready), .done(done), .rd_byte(rd_byte),
    .we_n(we_n), .re_n(re_n), .cle(cle), .ale(ale),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .rb_n(rb_n)
  );

  typedef struct {
    int    su;
    int    lo;
    int    hi;
    bit    c;
    bit    a;
    int    dat;
    bit    rd;
    string tag;
  } exp_t;

  exp_t exq[$];
  bit   p_addr = 1'b0;
  bit   p_write = 1'b0;
  int   wait_busy = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int fl(input int i);
    return int'(tim_a[i*4 +: 4]);
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int f1(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  task automatic issue(input logic [2:0] k, input logic [7:0] b, input string tag);
    exp_t e;
    bit   wr;
    wr = (k <= 3'd2);
    e.tag = tag; e.c = (k == 3'd0); e.a = (k == 3'd1); e.rd = (k == 3'd3);
    e.dat = b;
    if (k == 3'd4) begin
      e.su = (wait_busy > 0) ? wait_busy : f1(fl(1)) + 1;
      e.lo = 0; e.hi = 0; e.dat = -1;
    end else if (k == 3'd3) begin
      e.su = p_write ? mx(fl(7) + 2, f1(fl(2))) : fl(7) + 2;
      e.lo = f1(fl(0)); e.hi = f1(fl(6));
    end else begin
      e.su = (k == 3'd2 && p_addr) ? mx(fl(3) + 1, int'(tim_b) + 2) : fl(3) + 1;
      e.lo = f1(fl(5)); e.hi = f1(fl(4));
    end
    if (k <= 3'd4) begin
      exq.push_back(e);
      n_exp++;
      p_addr = (k == 3'd1);
      p_write = wr;
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (k == 3'd3) dq_in = b;
    req_valid = 1'b1; req_kind = k; req_byte = b;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: measures each phase and compares on done
  int   m_su = 0, m_lo = 0, m_hi = 0;
  bit   seen_lo = 1'b0, m_c = 1'b0, m_a = 1'b0;
  int   m_dq = -1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!req_ready) begin
        if (!we_n || !re_n) begin
          m_lo++; seen_lo = 1'b1;
          m_c = cle; m_a = ale;
          if (!we_n) m_dq = (dq_oe ? int'(dq_out) : -2);
        end else if (seen_lo) m_hi++;
        else m_su++;
      end
      if (done) begin
        n_done++;
        if (exq.size() == 0) begin
          chk("R8 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exq.pop_front();
          chk({e.tag, " setup"}, m_su, e.su);
          chk({e.tag, " low"}, m_lo, e.lo);
          chk({e.tag, " high"}, m_hi, e.hi);
          if (e.lo > 0) begin
            chk({e.tag, " R2 cle"}, int'(m_c), int'(e.c));
            chk({e.tag, " R2 ale"}, int'(m_a), int'(e.a));
            if (e.rd) chk({e.tag, " R5 rd_byte"}, int'(rd_byte), e.dat);
            else      chk({e.tag, " R2 dq_out"}, m_dq, e.dat);
          end
        end
        m_su = 0; m_lo = 0; m_hi = 0; seen_lo = 1'b0; m_dq = -1;
      end
    end
  end

  task automatic drain();
    @(negedge clk);
    while (!req_ready || exq.size() != 0) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 we_n", int'(we_n), 1);
    chk("R1 re_n", int'(re_n), 1);
    chk("R1 cle_ale_oe", int'({cle, ale, dq_oe}), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 rd_byte", int'(rd_byte), 0);

    // fields: crr rh wp wh cs whr wb rp (high to low nibble)
    tim_a = 32'h0_1_3_2_1_6_2_3;
    tim_b = 4'd5;
    issue(3'd0, 8'h70, "R2 cmd");
    issue(3'd1, 8'h12, "R2 addr");
    issue(3'd2, 8'hA5, "R3 data after addr");
    issue(3'd2, 8'h5A, "R3 data after data");
    issue(3'd3, 8'h3C, "R4 read after write");
    issue(3'd3, 8'hC3, "R4 read after read");
    drain();

    // zero fields: one-clock floor and offsets
    tim_a = '0; tim_b = '0;
    issue(3'd0, 8'hFF, "R2 zero cmd");
    issue(3'd3, 8'h81, "R4 zero read");
    issue(3'd4, 8'h00, "R6 zero wait");
    drain();

    // R7 change during a running cycle
    tim_a = 32'h0_0_4_0_0_0_0_0;
    issue(3'd0, 8'h11, "R7 old value");
    tim_a = 32'h0_0_9_0_0_0_0_0;
    issue(3'd0, 8'h22, "R7 new value");
    drain();

    // R6 wait with device busy past the minimum wait
    tim_a = 32'h0_0_0_0_0_0_2_0;
    rb_n = 1'b0;
    wait_busy = 10;
    issue(3'd4, 8'h00, "R6 busy wait");
    repeat (9) @(negedge clk);
    rb_n = 1'b1;
    wait_busy = 0;
    drain();
    issue(3'd4, 8'h00, "R6 ready wait");
    drain();

    // R8 undefined kinds leave the bus idle
    for (int k = 5; k < 8; k++) begin
      issue(3'(k), 8'hEE, "R8");
      chk("R8 ready after bad kind", int'(req_ready), 1);
      chk("R8 strobes idle", int'({we_n, re_n}), 3);
    end
    repeat (5) @(negedge clk);
    issue(3'd1, 8'h34, "R9 addr after bad kinds");
    drain();
    repeat (3) @(negedge clk);

    chk("R5 done count", n_done, n_exp);
    chk("R9 queue empty", exq.size(), 0);
    summary();
    $finish;
  end
endmodule